// File: doc/BRIEF.md
# Integer Operate Execution Stage

This block carries out the register-to-register integer operations of a 64-bit load/store processor. Each accepted instruction word is in the operate layout; alongside it come the values already read for the two source registers and the present value of the destination register. The stage picks the second operand from either the second source register or an 8-bit literal carried in the word. It then forms a sum, difference, scaled sum, logical OR, 0/1 compare result or conditional-move result. It returns the 64-bit result, the destination index, a write-enable and an illegal-function flag one cycle later.

The input and output sides are valid/ready streams. An input is taken on a cycle where `in_valid` and `in_ready` are both high. A result is held and stays stable from the cycle it appears until a cycle where `out_ready` is high. While a result is held and `out_ready` is low, `in_ready` is low. A new word can be taken in the same cycle the previous result leaves, so full throughput needs no bubble. The register file, fetch, memory access and branches lie outside the block.

Top module: `iopx_unit`

## Requirements
- R1: Bit 12 of the word selects the layout. When it is 0, the second operand is the second source value, and the source index sits in bits [20:16].
- R2: When bit 12 is 1, bits [20:13] form an 8-bit literal that is zero-extended to 64 bits and used as the second operand. The second source value has no effect in this layout.
- R3: The function code is in bits [11:5]. Function 7'h00 returns A + B and 7'h01 returns A − B, both modulo 2^64.
- R4: Function 7'h02 returns 4·A + B and 7'h03 returns 8·A + B, both modulo 2^64.
- R5: The compares write 1 when their condition holds and 0 otherwise. They are 7'h10 equal, 7'h11 signed less-than, 7'h12 signed less-or-equal, 7'h13 unsigned less-than and 7'h14 unsigned less-or-equal.
- R6: The conditional moves test A against zero: 7'h20 eq, 7'h21 ne, 7'h22 gt, 7'h23 ge, 7'h24 lt, 7'h25 le, all signed. When the test holds, the result is B and write-enable is high. When it fails, write-enable is low and the result equals the destination value supplied with the word.
- R7: The first source index is in bits [25:21] and the destination index in [4:0]. A source index of 31 reads as zero whatever value is supplied. A destination of 31 forces write-enable low.
- R8: Function 7'h04 returns the bitwise OR of A and B. With both sources indexed 31 in register layout, it returns zero.
- R9: Any other function code sets the illegal flag, forces write-enable low and returns zero.
- R10: A result appears with `out_valid` high one cycle after its word is accepted. Reset clears `out_valid` and leaves `in_ready` high.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Stage can take a word this cycle |
| instr | input | 32 | Operate-layout instruction word |
| ra_val | input | 64 | Value read for the first source |
| rb_val | input | 64 | Value read for the second source |
| rc_val | input | 64 | Present value of the destination |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Computed value |
| out_dest | output | 5 | Destination register index |
| out_wen | output | 1 | Register write permitted |
| out_illegal | output | 1 | Function code not recognised |

## Verification
The assertions assume that the consumer eventually raises `out_ready`. They also assume that the supplied register values correspond to the indices in the word, although the stage itself zeroes index 31. The bench drives every word for the full handshake at the falling edge. It keeps `out_ready` high except in the back-pressure scenario, where it holds a second word on the input until the first result is taken. It deliberately supplies nonzero values for index-31 sources and a nonzero second source in literal layout, so that the zeroing and the selection are visible at the result.

// File: rtl/iopx_pkg.sv
package iopx_pkg;
  parameter int XLEN   = 64;
  parameter int REGW   = 5;
  parameter int LITW   = 8;
  parameter int FNW    = 7;
  parameter int IW     = 32;
  localparam logic [REGW-1:0] ZERO_REG = '1;

  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_S4ADD, OP_S8ADD, OP_OR,
    OP_CMPEQ, OP_CMPLT, OP_CMPLE, OP_CMPULT, OP_CMPULE,
    OP_CMOVEQ, OP_CMOVNE, OP_CMOVGT, OP_CMOVGE, OP_CMOVLT, OP_CMOVLE,
    OP_BAD
  } op_e;

  function automatic op_e fn_to_op(input logic [FNW-1:0] fn);
    case (fn)
      7'h00: return OP_ADD;
      7'h01: return OP_SUB;
      7'h02: return OP_S4ADD;
      7'h03: return OP_S8ADD;
      7'h04: return OP_OR;
      7'h10: return OP_CMPEQ;
      7'h11: return OP_CMPLT;
      7'h12: return OP_CMPLE;
      7'h13: return OP_CMPULT;
      7'h14: return OP_CMPULE;
      7'h20: return OP_CMOVEQ;
      7'h21: return OP_CMOVNE;
      7'h22: return OP_CMOVGT;
      7'h23: return OP_CMOVGE;
      7'h24: return OP_CMOVLT;
      7'h25: return OP_CMOVLE;
      default: return OP_BAD;
    endcase
  endfunction
endpackage

// File: rtl/iopx_decode.sv
module iopx_decode
  import iopx_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic [IW-1:0]   instr,
  input  logic [XW-1:0]   ra_val,
  input  logic [XW-1:0]   rb_val,
  output op_e             op,
  output logic [XW-1:0]   opnd_a,
  output logic [XW-1:0]   opnd_b,
  output logic [REGW-1:0] dest
);
  localparam int FLAG_BIT = 12;
  localparam int FN_LO    = 5;
  localparam int LIT_LO   = 13;
  localparam int RB_LO    = 16;
  localparam int RA_LO    = 21;

  logic [REGW-1:0] ra_idx, rb_idx;
  logic [LITW-1:0] lit;
  logic            lit_form;
  logic            unused_bits;

  assign ra_idx   = instr[RA_LO +: REGW];
  assign rb_idx   = instr[RB_LO +: REGW];
  assign lit      = instr[LIT_LO +: LITW];
  assign lit_form = instr[FLAG_BIT];
  assign dest     = instr[REGW-1:0];
  assign op       = fn_to_op(instr[FN_LO +: FNW]);
  assign unused_bits = ^{instr[IW-1:RA_LO+REGW]};

  always_comb begin
    opnd_a = (ra_idx == ZERO_REG) ? '0 : ra_val;
    if (lit_form)
      opnd_b = {{(XW-LITW){1'b0}}, lit};
    else
      opnd_b = (rb_idx == ZERO_REG) ? '0 : rb_val;
  end
endmodule

// File: rtl/iopx_alu.sv
module iopx_alu
  import iopx_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  op_e           op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  logic [XW-1:0] rc_old,
  output logic [XW-1:0] result,
  output logic          wen,
  output logic          illegal
);
  logic a_zero, a_neg, cond;
  logic is_cmp;

  assign a_zero = (a == '0);
  assign a_neg  = a[XW-1];

  always_comb begin
    case (op)
      OP_CMOVEQ: cond = a_zero;
      OP_CMOVNE: cond = !a_zero;
      OP_CMOVGT: cond = !a_neg && !a_zero;
      OP_CMOVGE: cond = !a_neg;
      OP_CMOVLT: cond = a_neg;
      OP_CMOVLE: cond = a_neg || a_zero;
      default:   cond = 1'b0;
    endcase
  end

  always_comb begin
    result  = '0;
    wen     = 1'b1;
    illegal = 1'b0;
    is_cmp  = 1'b0;
    case (op)
      OP_ADD:    result = a + b;
      OP_SUB:    result = a - b;
      OP_S4ADD:  result = (a << 2) + b;
      OP_S8ADD:  result = (a << 3) + b;
      OP_OR:     result = a | b;
      OP_CMPEQ:  begin is_cmp = 1'b1; result = {{(XW-1){1'b0}}, a == b}; end
      OP_CMPLT:  begin is_cmp = 1'b1; result = {{(XW-1){1'b0}}, $signed(a) <  $signed(b)}; end
      OP_CMPLE:  begin is_cmp = 1'b1; result = {{(XW-1){1'b0}}, $signed(a) <= $signed(b)}; end
      OP_CMPULT: begin is_cmp = 1'b1; result = {{(XW-1){1'b0}}, a <  b}; end
      OP_CMPULE: begin is_cmp = 1'b1; result = {{(XW-1){1'b0}}, a <= b}; end
      OP_CMOVEQ, OP_CMOVNE, OP_CMOVGT,
      OP_CMOVGE, OP_CMOVLT, OP_CMOVLE: begin
        result = cond ? b : rc_old;
        wen    = cond;
      end
      default: begin
        illegal = 1'b1;
        wen     = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (is_cmp)
      a_r5_cmp_is_bool: assert (result[XW-1:1] == '0);
  end
endmodule

// File: rtl/iopx_unit.sv
module iopx_unit
  import iopx_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IW-1:0]   instr,
  input  logic [XW-1:0]   ra_val,
  input  logic [XW-1:0]   rb_val,
  input  logic [XW-1:0]   rc_val,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XW-1:0]   out_result,
  output logic [REGW-1:0] out_dest,
  output logic            out_wen,
  output logic            out_illegal
);
  op_e             op;
  logic [XW-1:0]   opa, opb, res;
  logic [REGW-1:0] dest;
  logic            wen_raw, ill;
  logic            accept;

  iopx_decode #(.XW(XW)) u_dec (
    .instr(instr), .ra_val(ra_val), .rb_val(rb_val),
    .op(op), .opnd_a(opa), .opnd_b(opb), .dest(dest)
  );

  iopx_alu #(.XW(XW)) u_alu (
    .op(op), .a(opa), .b(opb), .rc_old(rc_val),
    .result(res), .wen(wen_raw), .illegal(ill)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dest    <= '0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= res;
        out_dest    <= dest;
        out_wen     <= wen_raw && (dest != ZERO_REG);
        out_illegal <= ill;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  a_r10_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dest)
      && $stable(out_wen) && $stable(out_illegal));
  a_r11_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wen);
  a_r7_dest_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dest == ZERO_REG |-> !out_wen);
endmodule

// File: tb/test_iopx_unit.sv
module test_iopx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] instr;
  logic [63:0] ra_val, rb_val, rc_val, out_result;
  logic [4:0]  out_dest;
  logic        out_wen, out_illegal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iopx_unit i_iopx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_dest(out_dest), .out_wen(out_wen), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] mk_reg(input logic [6:0] fn, input logic [4:0] a,
                                         input logic [4:0] b, input logic [4:0] c);
    return {6'h11, a, b, 3'b000, 1'b0, fn, c};
  endfunction
  function automatic logic [31:0] mk_lit(input logic [6:0] fn, input logic [4:0] a,
                                         input logic [7:0] l, input logic [4:0] c);
    return {6'h11, a, l, 1'b1, fn, c};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] w, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] c, input logic [63:0] er,
                        input logic ew, input logic ei);
    @(negedge clk);
    instr = w; ra_val = a; rb_val = b; rc_val = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, out_result, er);
    check({tag, " dest"}, {59'd0, out_dest}, {59'd0, w[4:0]});
    check({tag, " wen"}, {63'd0, out_wen}, {63'd0, ew});
    check({tag, " illegal"}, {63'd0, out_illegal}, {63'd0, ei});
  endtask

  task automatic t_reset;
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_arith;
    run_op("R1 R3 add", mk_reg(7'h00, 5'd1, 5'd2, 5'd3), 64'd5, 64'd7, 64'd0, 64'd12, 1'b1, 1'b0);
    run_op("R3 add wrap", mk_reg(7'h00, 5'd1, 5'd2, 5'd3), '1, 64'd2, 64'd0, 64'd1, 1'b1, 1'b0);
    run_op("R3 sub", mk_reg(7'h01, 5'd1, 5'd2, 5'd3), 64'd3, 64'd5, 64'd0,
           64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0);
    run_op("R2 literal add", mk_lit(7'h00, 5'd4, 8'hFF, 5'd6), 64'd10, 64'h1234, 64'd0,
           64'h109, 1'b1, 1'b0);
    run_op("R4 s4add", mk_reg(7'h02, 5'd1, 5'd2, 5'd3), 64'd3, 64'd100, 64'd0, 64'd112, 1'b1, 1'b0);
    run_op("R4 s8add lit", mk_lit(7'h03, 5'd1, 8'd5, 5'd3), 64'd3, 64'd999, 64'd0, 64'd29, 1'b1, 1'b0);
    run_op("R8 or", mk_reg(7'h04, 5'd1, 5'd2, 5'd3), 64'hF0, 64'h0F, 64'd0, 64'hFF, 1'b1, 1'b0);
  endtask

  task automatic t_compare;
    run_op("R5 cmplt signed", mk_reg(7'h11, 5'd1, 5'd2, 5'd3), '1, 64'd1, 64'd9, 64'd1, 1'b1, 1'b0);
    run_op("R5 cmpult unsigned", mk_reg(7'h13, 5'd1, 5'd2, 5'd3), '1, 64'd1, 64'd9, 64'd0, 1'b1, 1'b0);
    run_op("R5 cmple equal", mk_reg(7'h12, 5'd1, 5'd2, 5'd3), 64'd7, 64'd7, 64'd9, 64'd1, 1'b1, 1'b0);
    run_op("R5 cmpeq differ", mk_reg(7'h10, 5'd1, 5'd2, 5'd3), 64'd7, 64'd8, 64'd9, 64'd0, 1'b1, 1'b0);
    run_op("R5 cmpule", mk_reg(7'h14, 5'd1, 5'd2, 5'd3), 64'd8, 64'd8, 64'd9, 64'd1, 1'b1, 1'b0);
  endtask

  task automatic t_cmov;
    run_op("R6 cmovgt pass", mk_reg(7'h22, 5'd1, 5'd2, 5'd3), 64'd5, 64'hAB, 64'hCD, 64'hAB, 1'b1, 1'b0);
    run_op("R6 cmovgt fail", mk_reg(7'h22, 5'd1, 5'd2, 5'd3), -64'sd5, 64'hAB, 64'hCD, 64'hCD, 1'b0, 1'b0);
    run_op("R6 cmovle zero", mk_reg(7'h25, 5'd1, 5'd2, 5'd3), 64'd0, 64'h11, 64'h22, 64'h11, 1'b1, 1'b0);
    run_op("R6 R7 cmoveq ra31", mk_reg(7'h20, 5'd31, 5'd2, 5'd3), 64'd77, 64'h5A, 64'h22, 64'h5A, 1'b1, 1'b0);
  endtask

  task automatic t_zero_reg;
    run_op("R7 R8 or both 31", mk_reg(7'h04, 5'd31, 5'd31, 5'd3), 64'hDEAD, 64'hBEEF, 64'd0,
           64'd0, 1'b1, 1'b0);
    run_op("R7 dest 31", mk_reg(7'h00, 5'd1, 5'd2, 5'd31), 64'd1, 64'd1, 64'd0, 64'd2, 1'b0, 1'b0);
  endtask

  task automatic t_illegal;
    run_op("R9 bad code", mk_reg(7'h7F, 5'd1, 5'd2, 5'd3), 64'd1, 64'd2, 64'd3, 64'd0, 1'b0, 1'b1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    instr = mk_reg(7'h00, 5'd1, 5'd2, 5'd3); ra_val = 64'd1; rb_val = 64'd2; rc_val = 0;
    in_valid = 1'b1;
    @(negedge clk);
    instr = mk_reg(7'h00, 5'd1, 5'd2, 5'd4); ra_val = 64'd10; rb_val = 64'd20;
    check("R11 stall in_ready", {63'd0, in_ready}, 64'd0);
    check("R11 first result", out_result, 64'd3);
    @(negedge clk);
    check("R11 held result", out_result, 64'd3);
    check("R11 held dest", {59'd0, out_dest}, 64'd3);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 R10 second result", out_result, 64'd30);
    check("R11 second dest", {59'd0, out_dest}, 64'd4);
    @(negedge clk);
    check("R10 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    instr = '0; ra_val = '0; rb_val = '0; rc_val = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_arith();
    t_compare();
    t_cmov();
    t_zero_reg();
    t_illegal();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule